// File: doc/BRIEF.md
# Synchronizable Timing NCO

This block is a phase-accumulating numerically controlled oscillator that paces a resampler. On each clock with the sample enable high, a 32-bit phase register advances by a tuning increment. The increment is N = (f_out / F_in) × 2^32, where F_in is the resampler input rate, so it can express any rate from zero up to F_in. The block gives out the phase and a one-cycle strobe each time the phase wraps.

Software programs the block through a simple write port with an enable, an address and data. The center frequency is double-buffered. A write places a new value in a holding register, and the running oscillator does not see it. The value reaches the active register when software writes to an update address, or when an enabled external sync pulse arrives. That update can also restart the phase, so the oscillator starts from a known phase at the moment of the event. A signed fine-offset input can be added to the center frequency. Its usable width is selectable.

Top module: `timing_nco`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `phase_out` and `wrap_out` are 0. The configuration, holding and active registers also clear to 0.
- R2: A write to address 1 loads only the holding register. `phase_out` keeps advancing by the previous increment until a transfer occurs.
- R3: A write to address 2 (data ignored) copies the holding register to the active register. The phase advances by the new increment from the next enabled cycle onward.
- R4: When configuration bit 5 is 1, a rising edge on `sync_in` copies the holding register to the active register in the same cycle as that edge.
- R5: When configuration bit 5 is 0, `sync_in` has no effect on the active frequency or on the phase.
- R6: Configuration bits 4:3 select how many low bits of `offset_in` are used: 00 = 8, 01 = 16, 10 = 24, 11 = 32. Those bits are placed at the top of the 32-bit field with zeros below them, and are read as a two's-complement offset. Bits of `offset_in` above the selected width are ignored.
- R7: Configuration bit 2 enables the offset. When it is 0, the increment is the active center frequency alone. When it is 1, the increment is the center frequency plus the aligned offset, modulo 2^32.
- R8: While configuration bit 1 is 1, the accumulator feedback is zero. `phase_out` then becomes the increment on each enabled cycle, or 0 when the sample enable is low.
- R9: When configuration bit 0 is 1, every transfer (from the strobe or from sync) zeroes the feedback on the edge that performs the transfer. On that edge the new phase equals the increment that was in force before the transfer.
- R10: The phase changes only on cycles with `samp_en` high or with the feedback zeroed. With `samp_en` low and no zeroing, the phase holds.
- R11: `wrap_out` is high for exactly the one cycle after an enabled phase addition that carries out of bit 31.
- R12: When the update strobe and an enabled sync edge fall in the same cycle, one transfer takes place. The phase is zeroed once, just as it would be for either source alone.
- R13: Writes to address 0 load configuration bits 5:0 from `wr_data[5:0]`. The new configuration takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register address: 0 config, 1 holding frequency, 2 update strobe |
| wr_data | input | 32 | Register write data |
| sync_in | input | 1 | External sync; its rising edge transfers when enabled |
| samp_en | input | 1 | Advance the phase on this cycle |
| offset_in | input | 32 | Signed fine-offset frequency, low bits used per width select |
| phase_out | output | 32 | Registered accumulated phase |
| wrap_out | output | 1 | One-cycle strobe on phase carry-out |

## Verification
Two events can fall in the same cycle: the software update strobe and an enabled external sync edge. Either one alone performs a transfer and, with phase zeroing on, restarts the accumulator. The bench raises `sync_in` in the same cycle as the address-2 write. It then checks two things. The phase on that edge must equal the old increment, showing the feedback was cleared once. On the following cycle the phase must advance by exactly the newly transferred frequency. A reference model built from the requirements follows every cycle, so any double transfer, lost transfer or misplaced zeroing appears as a phase mismatch.

// File: rtl/timing_nco_pkg.sv
package timing_nco_pkg;

  // Configuration word, bit 5 down to bit 0
  typedef struct packed {
    logic       ext_sync_en;  // bit 5
    logic [1:0] ofs_width;    // bits 4:3
    logic       ofs_en;       // bit 2
    logic       acc_clear;    // bit 1
    logic       zero_on_upd;  // bit 0
  } nco_cfg_t;

  localparam int CFG_W     = $bits(nco_cfg_t);
  localparam int ADDR_CFG  = 0;
  localparam int ADDR_HOLD = 1;
  localparam int ADDR_UPD  = 2;

endpackage

// File: rtl/nco_regs.sv
module nco_regs
  import timing_nco_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [PHASE_W-1:0] wr_data,
  input  logic               sync_in,
  output nco_cfg_t           cfg_q,
  output logic [PHASE_W-1:0] active_q,
  output logic               xfer_zero
);

  logic [PHASE_W-1:0] hold_q;
  logic               sync_q;
  logic               wr_cfg, wr_hold, wr_upd;
  logic               sync_fire, xfer;

  assign wr_cfg    = wr_en && (wr_addr == ADDR_W'(ADDR_CFG));
  assign wr_hold   = wr_en && (wr_addr == ADDR_W'(ADDR_HOLD));
  assign wr_upd    = wr_en && (wr_addr == ADDR_W'(ADDR_UPD));
  assign sync_fire = cfg_q.ext_sync_en && sync_in && !sync_q;
  // strobe and sync merge into one transfer
  assign xfer      = wr_upd || sync_fire;
  assign xfer_zero = xfer && cfg_q.zero_on_upd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      hold_q   <= '0;
      active_q <= '0;
      sync_q   <= 1'b0;
    end else begin
      sync_q <= sync_in;
      if (wr_cfg)  cfg_q    <= nco_cfg_t'(wr_data[CFG_W-1:0]);
      if (wr_hold) hold_q   <= wr_data;
      if (xfer)    active_q <= hold_q;
    end
  end

  // R5
  ext_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.ext_sync_en && !wr_upd) |=> $stable(active_q));

  // R2
  hold_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hold && !sync_fire) |=> $stable(active_q));

  // R3
  strobe_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    wr_upd |=> (active_q == $past(hold_q)));

endmodule

// File: rtl/nco_offset.sv
module nco_offset
  import timing_nco_pkg::*;
#(
  parameter int PHASE_W = 32
) (
  input  logic [PHASE_W-1:0] offset_in,
  input  logic [1:0]         width_sel,
  input  logic               enable,
  output logic [PHASE_W-1:0] ofs_term
);

  localparam int STEP = PHASE_W / 4;

  logic [PHASE_W-1:0] cand [4];

  for (genvar g = 0; g < 4; g++) begin : g_width
    localparam int W = STEP * (g + 1);
    assign cand[g] = PHASE_W'(offset_in[W-1:0]) << (PHASE_W - W);
  end

  always_comb begin
    ofs_term = enable ? cand[width_sel] : '0;
  end

endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               samp_en,
  input  logic               zero_fb,
  input  logic [PHASE_W-1:0] incr,
  output logic [PHASE_W-1:0] phase_q,
  output logic               wrap_q
);

  logic [PHASE_W-1:0] fb;
  logic [PHASE_W:0]   sum;

  assign fb  = zero_fb ? '0 : phase_q;
  assign sum = {1'b0, fb} + {1'b0, incr};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      phase_q <= samp_en ? sum[PHASE_W-1:0] : fb;
      wrap_q  <= samp_en && sum[PHASE_W];
    end
  end

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!samp_en && !zero_fb) |=> ($stable(phase_q) && !wrap_q));

  // R11
  wrap_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (samp_en && !zero_fb) |=> (wrap_q == (phase_q < $past(phase_q))));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_fb && !samp_en) |=> (phase_q == '0 && !wrap_q));

endmodule

// File: rtl/timing_nco.sv
module timing_nco
  import timing_nco_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [PHASE_W-1:0] wr_data,
  input  logic               sync_in,
  input  logic               samp_en,
  input  logic [PHASE_W-1:0] offset_in,
  output logic [PHASE_W-1:0] phase_out,
  output logic               wrap_out
);

  nco_cfg_t           cfg;
  logic [PHASE_W-1:0] active_freq;
  logic [PHASE_W-1:0] ofs_term;
  logic [PHASE_W-1:0] incr;
  logic               xfer_zero;
  logic               zero_fb;

  nco_regs #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sync_in   (sync_in),
    .cfg_q     (cfg),
    .active_q  (active_freq),
    .xfer_zero (xfer_zero)
  );

  nco_offset #(.PHASE_W(PHASE_W)) u_offset (
    .offset_in (offset_in),
    .width_sel (cfg.ofs_width),
    .enable    (cfg.ofs_en),
    .ofs_term  (ofs_term)
  );

  assign incr    = active_freq + ofs_term;
  assign zero_fb = cfg.acc_clear || xfer_zero;

  nco_accum #(.PHASE_W(PHASE_W)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .samp_en (samp_en),
    .zero_fb (zero_fb),
    .incr    (incr),
    .phase_q (phase_out),
    .wrap_q  (wrap_out)
  );

  // R9
  zero_on_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_zero && samp_en) |=> (phase_out == $past(incr)));

endmodule

// File: tb/timing_nco_bench.sv
module timing_nco_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        sync_in = 1'b0;
  logic        samp_en = 1'b0;
  logic [31:0] offset_in = '0;
  logic [31:0] phase_out;
  logic        wrap_out;

  int tests = 0;
  int fails = 0;

  // reference model state
  logic [5:0]  m_cfg;
  logic [31:0] m_hold, m_active, m_phase;
  logic        m_wrap, m_sync_q;

  always #2 clk = ~clk;

  timing_nco u_timing_nco (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .samp_en(samp_en), .offset_in(offset_in),
    .phase_out(phase_out), .wrap_out(wrap_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_offset();
    int w;
    logic [31:0] mask;
    if (!m_cfg[2]) return 32'h0;
    w = 8 * (int'(m_cfg[4:3]) + 1);
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (offset_in & mask) << (32 - w);
  endfunction

  // one clock, model advanced from the requirements, outputs compared
  task automatic step();
    logic        upd, zero;
    logic [31:0] inc, fb;
    logic [32:0] sum;
    upd  = (wr_en && wr_addr == 2'd2) || (m_cfg[5] && sync_in && !m_sync_q);
    zero = m_cfg[1] || (m_cfg[0] && upd);
    inc  = m_active + m_offset();
    fb   = zero ? 32'h0 : m_phase;
    sum  = {1'b0, fb} + {1'b0, inc};
    @(posedge clk);
    m_phase  = samp_en ? sum[31:0] : fb;
    m_wrap   = samp_en && sum[32];
    if (upd) m_active = m_hold;
    if (wr_en && wr_addr == 2'd0) m_cfg = wr_data[5:0];
    if (wr_en && wr_addr == 2'd1) m_hold = wr_data;
    m_sync_q = sync_in;
    #1;
    check("R10 phase", phase_out, m_phase);
    check("R11 wrap", {31'h0, wrap_out}, {31'h0, m_wrap});
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    m_cfg = '0; m_hold = '0; m_active = '0; m_phase = '0; m_wrap = 0; m_sync_q = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 phase in reset", phase_out, 32'h0);
    check("R1 wrap in reset", {31'h0, wrap_out}, 32'h0);
    rst = 1'b0;
    samp_en = 1'b1;
    step();
    check("R1 phase after reset", phase_out, 32'h0);
  endtask

  task automatic t_hold_only();
    wr(2'd0, 32'h0);          // R13 config write
    wr(2'd1, 32'h1000_0000);
    repeat (3) step();
    check("R2 holding not visible", phase_out, 32'h0);
  endtask

  task automatic t_strobe();
    int wraps = 0;
    wr(2'd2, 32'hDEAD_BEEF);
    check("R3 strobe edge uses old increment", phase_out, 32'h0);
    step();
    check("R3 new increment applied", phase_out, 32'h1000_0000);
    if (wrap_out) wraps++;
    for (int i = 0; i < 15; i++) begin
      step();
      if (wrap_out) wraps++;
    end
    check("R11 one wrap per revolution", wraps, 1);
    check("R11 wrapped to zero", phase_out, 32'h0);
    samp_en = 1'b0;
    step(); step();
    check("R10 phase held while idle", phase_out, 32'h0);
    samp_en = 1'b1;
    step();
  endtask

  task automatic t_sync_disabled();
    logic [31:0] p0;
    wr(2'd1, 32'h2000_0000);
    sync_in = 1'b1; step(); sync_in = 1'b0;
    p0 = phase_out;
    step();
    check("R5 sync ignored when disabled", phase_out - p0, 32'h1000_0000);
  endtask

  task automatic t_sync_enabled();
    wr(2'd0, 32'h21);          // R13: ext sync + zero on update
    wr(2'd1, 32'h3000_0000);
    sync_in = 1'b1; step();
    check("R9 phase restarts at old increment", phase_out, 32'h1000_0000);
    step();                    // held high: no second edge
    sync_in = 1'b0;
    check("R4 sync transferred holding", phase_out, 32'h4000_0000);
  endtask

  task automatic t_offset();
    logic [31:0] p0;
    offset_in = 32'hABCD_EFFF;
    wr(2'd0, 32'h04);          // width 8, enabled
    p0 = phase_out; step();
    check("R6 8-bit offset -1 aligned", phase_out - p0, 32'h2F00_0000);
    offset_in = 32'hABCD_8000;
    wr(2'd0, 32'h0C);          // width 16
    p0 = phase_out; step();
    check("R6 16-bit offset aligned", phase_out - p0, 32'hB000_0000);
    offset_in = 32'h0000_0010;
    wr(2'd0, 32'h1C);          // width 32
    p0 = phase_out; step();
    check("R6 32-bit offset", phase_out - p0, 32'h3000_0010);
    wr(2'd0, 32'h18);          // width 32, disabled
    p0 = phase_out; step();
    check("R7 offset gated off", phase_out - p0, 32'h3000_0000);
  endtask

  task automatic t_clear();
    wr(2'd0, 32'h02);
    step(); step();
    check("R8 feedback held at zero", phase_out, 32'h3000_0000);
    samp_en = 1'b0;
    step();
    check("R8 cleared while idle", phase_out, 32'h0);
    samp_en = 1'b1;
  endtask

  task automatic t_both();
    wr(2'd0, 32'h21);
    wr(2'd1, 32'h0500_0000);
    step();
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = '0; sync_in = 1'b1;
    step();
    wr_en = 1'b0; sync_in = 1'b0;
    check("R12 single zeroing on joint update", phase_out, 32'h3000_0000);
    step();
    check("R12 single transfer of new value", phase_out, 32'h3500_0000);
  endtask

  initial begin
    t_reset();
    t_hold_only();
    t_strobe();
    t_sync_disabled();
    t_sync_enabled();
    t_offset();
    t_clear();
    t_both();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule